// File: doc/BRIEF.md
# Transmitter Mode and Startup Controller

This block turns three control lines of a small radio transmitter into an operating mode, and drives the enables that follow from it. The control lines are an amplitude-keying line, a frequency-keying line and an enable line that can be driven high, driven low or left floating. The floating case comes in as an enable value plus a separate "floating" flag. From these lines the block derives three modes. In power-down, everything is off. In idle, the enable line is held low while the keying lines move, so those lines can serve other devices without waking the transmitter. In powered-up mode, the oscillator and synthesizer run, the power amplifier follows the amplitude line and the frequency switch follows the frequency line.

When the block powers up, it also sequences startup. It first waits for the external clock-active indication, which tells it the crystal oscillator has settled. It then counts a lock-wait interval of a parameterised number of reference cycles, and only after that does it raise ready-to-transmit. A loss of enable at any point drops the block back to power-down or idle within one cycle and restarts the sequence.

All outputs are registered. Each one reflects the inputs sampled at the preceding clock edge.

Top module: `tx_mode_ctrl`

## Requirements
- R1: When `en_float_i` is 1, the effective enable is `ask_i | fsk_i` and `en_i` is ignored. When `en_float_i` is 0, the effective enable is `en_i`.
- R2: With effective enable 0 and `ask_i = fsk_i = 0`, the block is in power-down. In that mode `osc_pll_en_o`, `pa_en_o`, `fsk_sw_lowz_o` and `ready_o` are all 0, and `state_o` is 0 (OFF).
- R3: With `en_float_i = 0`, `en_i = 0` and `ask_i` or `fsk_i` at 1, the block is idle. All enables and `ready_o` are 0 and `state_o` is 1 (IDLE). Toggling the keying lines in this mode never powers the block up.
- R4: While the effective enable is 1, `osc_pll_en_o` is 1 and `pa_en_o` equals `ask_i`.
- R5: While powered up, `fsk_sw_lowz_o` is 1 (switch closed) when `fsk_i` is 0 and 0 (switch open) when `fsk_i` is 1. When not powered up, it is 0.
- R6: With `en_float_i = 0`, `en_i = 1` and both keying lines at 0, the block is powered up with the amplifier off and the switch closed.
- R7: On power-up the state becomes 2 (WAIT_CLK) and stays there until `clk_active_i` is sampled at 1. The state is then 3 (WAIT_LOCK) for exactly `LOCK_CYCLES` cycles, after which it becomes 4 (READY) with `ready_o` = 1.
- R8: Once the effective enable falls, the next clock edge gives state OFF or IDLE and `ready_o` = 0. A later power-up counts the full lock wait again from zero.
- R9: Every output changes at the clock edge that samples the causing input level, one cycle after that level is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ask_i | input | 1 | Amplitude-keying control line |
| fsk_i | input | 1 | Frequency-keying control line |
| en_i | input | 1 | Driven value of the enable line |
| en_float_i | input | 1 | 1 when the enable line is left floating |
| clk_active_i | input | 1 | Oscillator clock output has become active |
| osc_pll_en_o | output | 1 | Oscillator and synthesizer enable |
| pa_en_o | output | 1 | Power amplifier enable |
| fsk_sw_lowz_o | output | 1 | Frequency switch closed (low impedance) |
| ready_o | output | 1 | Ready to transmit |
| state_o | output | 3 | Controller state: 0 OFF, 1 IDLE, 2 WAIT_CLK, 3 WAIT_LOCK, 4 READY |

## Verification
The bench drives all three enable situations: floating with each keying line alone, driven high with both keying lines low, and driven low with the keying lines toggling. Together these tell apart the floating-OR rule, the idle mode and plain power-down. Startup is exercised with `clk_active_i` held low for several cycles and then raised, which checks both the clock wait and the exact lock-wait length. Enable is also dropped in the middle of the lock wait and again after ready; this shows that the timer restarts from zero and that ready falls at the next edge. During ready, the keying lines toggle to separate the amplifier and switch control from the startup state.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_WAIT_CLK  = 3'd2,
    ST_WAIT_LOCK = 3'd3,
    ST_READY     = 3'd4
  } ctrl_state_t;

  typedef struct packed {
    logic pwr;
    logic idle;
    logic pa;
    logic sw_lowz;
  } mode_req_t;
endpackage

// File: rtl/tx_mode_decode.sv
module tx_mode_decode
  import tx_mode_pkg::*;
(
  input  logic      ask,
  input  logic      fsk,
  input  logic      en_val,
  input  logic      en_float,
  output mode_req_t req
);
  logic keying_any;
  logic eff_en;

  always_comb begin
    keying_any  = ask | fsk;
    // floating enable line follows either keying line
    eff_en      = en_float ? keying_any : en_val;
    req.pwr     = eff_en;
    req.idle    = ~en_float & ~en_val & keying_any;
    req.pa      = eff_en & ask;
    req.sw_lowz = eff_en & ~fsk;
  end
endmodule

// File: rtl/tx_lock_timer.sv
module tx_lock_timer #(
  parameter int LOCK_CYCLES = 3250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
  import tx_mode_pkg::*;
#(
  parameter int LOCK_CYCLES = 3250
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pwr,
  input  logic        idle,
  input  logic        clk_active,
  output ctrl_state_t state,
  output logic        ready
);
  ctrl_state_t st_q, st_d;
  logic        lock_done;
  logic        rdy_q;

  tx_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q == ST_WAIT_LOCK),
    .done (lock_done)
  );

  always_comb begin
    st_d = st_q;
    if (!pwr) begin
      st_d = idle ? ST_IDLE : ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF, ST_IDLE: st_d = ST_WAIT_CLK;
        ST_WAIT_CLK:     if (clk_active) st_d = ST_WAIT_LOCK;
        ST_WAIT_LOCK:    if (lock_done) st_d = ST_READY;
        ST_READY:        st_d = ST_READY;
        default:         st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= (st_d == ST_READY);
    end
  end

  assign state = st_q;
  assign ready = rdy_q;

  p_ready_via_lock_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(st_q) == ST_WAIT_LOCK);
  p_drop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !pwr |=> !ready && (st_q == ST_OFF || st_q == ST_IDLE));
  p_wait_clk_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT_CLK && pwr && !clk_active) |=> st_q == ST_WAIT_CLK);
endmodule

// File: rtl/tx_mode_ctrl.sv
module tx_mode_ctrl
  import tx_mode_pkg::*;
#(
  parameter int LOCK_CYCLES = 3250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ask_i,
  input  logic       fsk_i,
  input  logic       en_i,
  input  logic       en_float_i,
  input  logic       clk_active_i,
  output logic       osc_pll_en_o,
  output logic       pa_en_o,
  output logic       fsk_sw_lowz_o,
  output logic       ready_o,
  output logic [2:0] state_o
);
  mode_req_t   req;
  ctrl_state_t st;

  tx_mode_decode u_dec (
    .ask      (ask_i),
    .fsk      (fsk_i),
    .en_val   (en_i),
    .en_float (en_float_i),
    .req      (req)
  );

  tx_start_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .pwr        (req.pwr),
    .idle       (req.idle),
    .clk_active (clk_active_i),
    .state      (st),
    .ready      (ready_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_pll_en_o  <= 1'b0;
      pa_en_o       <= 1'b0;
      fsk_sw_lowz_o <= 1'b0;
    end else begin
      osc_pll_en_o  <= req.pwr;
      pa_en_o       <= req.pa;
      fsk_sw_lowz_o <= req.sw_lowz;
    end
  end

  assign state_o = st;

  p_pa_needs_osc_r4: assert property (@(posedge clk) disable iff (rst)
    pa_en_o |-> osc_pll_en_o);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !osc_pll_en_o && !pa_en_o && !fsk_sw_lowz_o && !ready_o);
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OFF) |-> !osc_pll_en_o && !fsk_sw_lowz_o);
  p_ready_powered_r4: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> osc_pll_en_o);
endmodule

// File: tb/tx_mode_ctrl_bench.sv
module tx_mode_ctrl_bench;
  localparam int LOCK = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ask = 1'b0, fsk = 1'b0, en = 1'b0, en_fl = 1'b1, cact = 1'b0;
  logic osc, pa, sw, rdy;
  logic [2:0] st;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string req = "R2";
  bit started = 0;

  // reference model state
  int m_st = 0, m_cnt = 0;
  bit m_osc = 0, m_pa = 0, m_sw = 0, m_rdy = 0;

  always #4 clk = ~clk;

  tx_mode_ctrl #(.LOCK_CYCLES(LOCK)) u_tx_mode_ctrl (
    .clk(clk), .rst(rst), .ask_i(ask), .fsk_i(fsk), .en_i(en),
    .en_float_i(en_fl), .clk_active_i(cact),
    .osc_pll_en_o(osc), .pa_en_o(pa), .fsk_sw_lowz_o(sw),
    .ready_o(rdy), .state_o(st)
  );

  always @(posedge clk) begin
    bit on, idl;
    int nxt;
    cyc++;
    started = 1;
    if (rst) begin
      m_st <= 0; m_cnt <= 0; m_osc <= 0; m_pa <= 0; m_sw <= 0; m_rdy <= 0;
    end else begin
      on  = en_fl ? (ask || fsk) : en;
      idl = !en_fl && !en && (ask || fsk);
      nxt = m_st;
      if (!on) nxt = idl ? 1 : 0;
      else if (m_st <= 1) nxt = 2;
      else if (m_st == 2 && cact) nxt = 3;
      else if (m_st == 3 && m_cnt == LOCK - 1) nxt = 4;
      m_cnt <= (m_st == 3 && nxt == 3) ? m_cnt + 1 : 0;
      m_st  <= nxt;
      m_rdy <= (nxt == 4);
      m_osc <= on;
      m_pa  <= on && ask;
      m_sw  <= on && !fsk;
    end
  end

  task automatic chk(string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, nm, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    chk("state", st, m_st);
    chk("osc_pll_en", osc, m_osc);
    chk("pa_en", pa, m_pa);
    chk("sw_lowz", sw, m_sw);
    chk("ready", rdy, m_rdy);
  end

  task automatic drive(bit a, bit f, bit e, bit fl, bit c, int n);
    @(negedge clk);
    ask = a; fsk = f; en = e; en_fl = fl; cact = c;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req = "R2"; drive(0, 0, 0, 1, 0, 4);
    drive(0, 0, 0, 0, 0, 3);
    req = "R1"; drive(0, 1, 0, 1, 0, 6);      // floating enable, fsk only
    req = "R7"; drive(0, 1, 0, 1, 1, LOCK + 4);
    req = "R4"; drive(1, 1, 0, 1, 1, 3);
    req = "R5"; drive(1, 0, 0, 1, 1, 3);
    drive(0, 1, 0, 1, 1, 2);
    req = "R9"; drive(1, 1, 0, 1, 1, 1); drive(0, 1, 0, 1, 1, 2);
    req = "R8"; drive(0, 0, 0, 1, 1, 3);      // drop after ready
    drive(0, 1, 0, 1, 1, 6);                  // mid-lock
    drive(0, 0, 0, 1, 1, 2);
    drive(0, 1, 0, 1, 1, LOCK + 4);           // full wait again
    req = "R3"; drive(1, 0, 0, 0, 1, 2);
    drive(0, 1, 0, 0, 1, 1); drive(1, 1, 0, 0, 1, 2);
    for (int i = 0; i < 8; i++) drive(i[0], i[1], 0, 0, 1, 1);
    req = "R6"; drive(0, 0, 1, 0, 0, 4);
    drive(0, 0, 1, 0, 1, LOCK + 3);
    req = "R1"; drive(1, 0, 0, 1, 0, 3);      // floating enable, ask only
    drive(0, 0, 1, 1, 0, 3);                  // en_i ignored while floating
    req = "R4"; drive(1, 0, 0, 1, 1, LOCK + 4);
    req = "R2"; drive(0, 0, 0, 1, 0, 3);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule